// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous internal bus and a 128K x 8 asynchronous static RAM. It takes one read or write request at a time and turns it into a pin-level cycle. The cycle uses a 17-bit address and a shared bidirectional 8-bit data bus. The device has two chip-select lines of opposite polarity, an active-low write strobe and an active-low output enable. Every pin control comes straight from a flop, and each phase lasts a parameter-set number of clock cycles.

A write first selects the device with the address stable. After the setup count it drives the data and lowers the write strobe for the pulse count. It then raises the strobe while the selects, address and data stay in place for the hold count. The device latches the data on that rising strobe, because the strobe is the first control to deassert. A read selects the device and lowers the output enable for the access count. It samples the bus on the last access cycle and returns the byte with a one-cycle done pulse.

An expansion mode uses request address bit 17 to pick one of two chips that share the data bus. In this mode the active-high select is held asserted and each chip gets its own active-low select line. A request is taken only while the controller reports ready, so there is never more than one access in flight.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it: `req_ready`=1, `done`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_sel1_n`=2'b11. `mem_sel2` is 0 in normal mode and 1 in expansion mode.
- R2: `req_ready` is high only when the controller is idle. A request is accepted at a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after `done`. A request presented while `req_ready` is low has no effect on the pins, the memory contents or `done`.
- R3: A write (`req_write`=1) starts with SETUP_CYC cycles in which the device is selected, `mem_we_n`=1 and `mem_oe_n`=1. After these, `mem_we_n` is low for exactly PULSE_CYC cycles.
- R4: After `mem_we_n` rises, the selects, address and write data stay on the pins for HOLD_CYC further cycles. The data on `mem_dq` equals `req_wdata` in every strobe and hold cycle, so the device latches it at the rising strobe.
- R5: `mem_oe_n` stays high through the whole of a write. The controller drives `mem_dq` only in the strobe and hold phases, never while `mem_oe_n` is low and never while the device is deselected.
- R6: A read (`req_write`=0) holds the selects asserted, `mem_oe_n`=0 and `mem_we_n`=1 for ACCESS_CYC cycles. The value on `mem_dq` in the last of these cycles appears on `rd_data`.
- R7: `done` is high for exactly one cycle, the cycle after the last phase of the access. In that cycle the selects are deasserted and `mem_we_n`=`mem_oe_n`=1. `rd_data` keeps its value until the next read completes.
- R8: Select pattern. There are two active-low select lines (`mem_sel1_n[0]` and `mem_sel1_n[1]`) and one active-high select. In normal mode (EXPAND=0), an access drives `mem_sel1_n[0]` low and `mem_sel2` high. `mem_sel1_n[1]` stays high and `mem_sel2` is low when idle. In expansion mode (EXPAND=1), `mem_sel2` is always 1 and `mem_sel1_n[req_addr[17]]` is low during the access. At most one line of `mem_sel1_n` is ever low.
- R9: `mem_addr` equals `req_addr[16:0]` as captured at acceptance, and it does not change while the device is selected.
- R10: Each phase length (SETUP_CYC, PULSE_CYC, HOLD_CYC, ACCESS_CYC) is a parameter of at least 1. With all four at 1, a write is busy for 4 cycles and a read for 2, each counted up to and including the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W+1 | Word address; bit ADDR_W picks the chip in expansion mode |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last read byte |
| mem_addr | output | ADDR_W | Device address pins |
| mem_sel1_n | output | 2 | Active-low chip selects, one per chip |
| mem_sel2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | inout | DATA_W | Shared data bus |

## Verification
The two functions that can fall in the same cycle are the busy handshake and an access already in progress. A new request can arrive while a write strobe or read access is under way. The bench provokes this during part of the sweep: it keeps `req_valid` high for the edge after acceptance and swaps in the inverted byte as write data. It then judges at the ports. A lost or extra access would show up as a second `done`, a shifted strobe, or a read-back value that differs from the arithmetic reference. The same cycle-by-cycle pin checks run on a normal-mode instance with unequal phase lengths and on an expansion-mode instance at the minimum lengths, over every low-address byte of both chips.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int CHIP_CNT = 2;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WPULSE  = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_RACCESS = 3'd4,
        PH_FINISH  = 3'd5
    } phase_e;

    // Internal pin controls, all active-high.
    typedef struct packed {
        logic sel;
        logic wr_strobe;
        logic rd_enable;
        logic drive;
    } pin_ctl_t;

    function automatic pin_ctl_t phase_pins(phase_e ph);
        pin_ctl_t c;
        c = '0;
        case (ph)
            PH_WSETUP:  c.sel = 1'b1;
            PH_WPULSE:  begin c.sel = 1'b1; c.wr_strobe = 1'b1; c.drive = 1'b1; end
            PH_WHOLD:   begin c.sel = 1'b1; c.drive = 1'b1; end
            PH_RACCESS: begin c.sel = 1'b1; c.rd_enable = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic int count_width(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_sel_decode.sv
module sram_sel_decode
    import sram_ctrl_pkg::*;
#(
    parameter int EXPAND = 0
) (
    input  logic                active,
    input  logic                bank,
    output logic [CHIP_CNT-1:0] sel1_n,
    output logic                sel2
);
    generate
        if (EXPAND != 0) begin : g_expand
            always_comb begin
                for (int i = 0; i < CHIP_CNT; i++)
                    sel1_n[i] = ~(active && (bank == 1'(i)));
            end
            assign sel2 = 1'b1;
        end else begin : g_single
            logic unused_bank;
            assign unused_bank = bank;
            assign sel1_n = {{(CHIP_CNT-1){1'b1}}, ~active};
            assign sel2   = active;
        end
    endgenerate
endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drive_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] dq
);
    assign dq = drive_en ? wdata : {DATA_W{1'bz}};

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (capture)
            rdata <= dq;
    end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int EXPAND     = 0,
    parameter int SETUP_CYC  = 2,
    parameter int PULSE_CYC  = 3,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W:0]     req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [CHIP_CNT-1:0] mem_sel1_n,
    output logic                mem_sel2,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    inout  wire  [DATA_W-1:0]   mem_dq
);
    localparam int CNT_W = count_width(SETUP_CYC, PULSE_CYC, HOLD_CYC, ACCESS_CYC);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_CYC - 1);

    phase_e            ph_q, ph_d;
    pin_ctl_t          ctl_q;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              accept, capture;
    logic              bank_q;
    logic [DATA_W-1:0] wdata_q;
    logic              dq_drv_en;

    assign accept  = req_valid && (ph_q == PH_IDLE);
    assign capture = (ph_q == PH_RACCESS) && tmr_done;

    // Next phase and timer reload
    always_comb begin
        ph_d     = ph_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (ph_q)
            PH_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_write) begin
                    ph_d    = PH_WSETUP;
                    tmr_val = SETUP_LD;
                end else begin
                    ph_d    = PH_RACCESS;
                    tmr_val = ACCESS_LD;
                end
            end
            PH_WSETUP: if (tmr_done) begin
                ph_d     = PH_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = PULSE_LD;
            end
            PH_WPULSE: if (tmr_done) begin
                ph_d     = PH_WHOLD;
                tmr_load = 1'b1;
                tmr_val  = HOLD_LD;
            end
            PH_WHOLD:   if (tmr_done) ph_d = PH_FINISH;
            PH_RACCESS: if (tmr_done) ph_d = PH_FINISH;
            PH_FINISH:  ph_d = PH_IDLE;
            default:    ph_d = PH_IDLE;
        endcase
    end

    // Phase and pin-control flops: pins follow the phase with no added cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            ctl_q <= '0;
        end else begin
            ph_q  <= ph_d;
            ctl_q <= phase_pins(ph_d);
        end
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            bank_q   <= 1'b0;
            wdata_q  <= '0;
        end else if (accept) begin
            mem_addr <= req_addr[ADDR_W-1:0];
            bank_q   <= req_addr[ADDR_W];
            wdata_q  <= req_wdata;
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_sel_decode #(.EXPAND(EXPAND)) u_sel (
        .active (ctl_q.sel),
        .bank   (bank_q),
        .sel1_n (mem_sel1_n),
        .sel2   (mem_sel2)
    );

    assign dq_drv_en = ctl_q.drive;

    sram_dq_port #(.DATA_W(DATA_W)) u_dq (
        .clk      (clk),
        .rst      (rst),
        .drive_en (dq_drv_en),
        .wdata    (wdata_q),
        .capture  (capture),
        .rdata    (rd_data),
        .dq       (mem_dq)
    );

    assign mem_we_n  = ~ctl_q.wr_strobe;
    assign mem_oe_n  = ~ctl_q.rd_enable;
    assign req_ready = (ph_q == PH_IDLE);
    assign done      = (ph_q == PH_FINISH);
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int EXPAND = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_sel1_n,
    input logic              mem_sel2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              dq_drv_en
);
    logic selected;
    assign selected = (EXPAND != 0) ? (mem_sel1_n != 2'b11)
                                    : (!mem_sel1_n[0] && mem_sel2);

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    a_r5_no_read_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);

    a_r5_drive_gated: assert property (@(posedge clk) disable iff (rst)
        dq_drv_en |-> (mem_oe_n && selected));

    a_r3_strobe_selected: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (selected && dq_drv_en));

    a_r4_hold_after_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (selected && dq_drv_en));

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (selected && $past(selected)) |-> $stable(mem_addr));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_released: assert property (@(posedge clk) disable iff (rst)
        done |-> (!selected && mem_oe_n && mem_we_n));

    a_r8_one_chip: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_sel1_n));

    a_r8_fixed_line: assert property (@(posedge clk) disable iff (rst)
        (EXPAND != 0) ? mem_sel2 : mem_sel1_n[1]);
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W), .EXPAND(EXPAND)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done       (done),
    .mem_addr   (mem_addr),
    .mem_sel1_n (mem_sel1_n),
    .mem_sel2   (mem_sel2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .dq_drv_en  (dq_drv_en)
);

// File: tb/sim_sram_port_ctrl.sv
`timescale 1ns/1ps

module sim_sram_model (
    input logic        sel1_n,
    input logic        sel2,
    input logic        we_n,
    input logic        oe_n,
    input logic [16:0] addr,
    inout wire  [7:0]  dq
);
    logic [7:0] cells [256];
    logic       rd_on;

    assign rd_on = !sel1_n && sel2 && we_n && !oe_n;
    assign dq    = rd_on ? cells[addr[7:0]] : 8'bzzzzzzzz;

    always @(posedge we_n) begin
        if (!sel1_n && sel2)
            cells[addr[7:0]] <= dq;
    end
endmodule

module sim_sram_port_ctrl;
    localparam int S0 = 2, P0 = 3, H0 = 2, A0 = 3;
    localparam int S1 = 1, P1 = 1, H1 = 1, A1 = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;

    logic        rdy0, dn0, we0, oe0, s20;
    logic [7:0]  rd0;
    logic [16:0] ad0;
    logic [1:0]  s1n0;
    wire  [7:0]  dq0;

    logic        rdy1, dn1, we1, oe1, s21;
    logic [7:0]  rd1;
    logic [16:0] ad1;
    logic [1:0]  s1n1;
    wire  [7:0]  dq1;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] ref0 [256];
    logic [7:0] ref1 [2][256];

    always #10 clk = ~clk;

    sram_port_ctrl #(.EXPAND(0), .SETUP_CYC(S0), .PULSE_CYC(P0),
                     .HOLD_CYC(H0), .ACCESS_CYC(A0)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy0), .done(dn0),
        .rd_data(rd0), .mem_addr(ad0), .mem_sel1_n(s1n0), .mem_sel2(s20),
        .mem_we_n(we0), .mem_oe_n(oe0), .mem_dq(dq0));

    sram_port_ctrl #(.EXPAND(1), .SETUP_CYC(S1), .PULSE_CYC(P1),
                     .HOLD_CYC(H1), .ACCESS_CYC(A1)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy1), .done(dn1),
        .rd_data(rd1), .mem_addr(ad1), .mem_sel1_n(s1n1), .mem_sel2(s21),
        .mem_we_n(we1), .mem_oe_n(oe1), .mem_dq(dq1));

    sim_sram_model m0  (.sel1_n(s1n0[0]), .sel2(s20), .we_n(we0), .oe_n(oe0), .addr(ad0), .dq(dq0));
    sim_sram_model m10 (.sel1_n(s1n1[0]), .sel2(s21), .we_n(we1), .oe_n(oe1), .addr(ad1), .dq(dq1));
    sim_sram_model m11 (.sel1_n(s1n1[1]), .sel2(s21), .we_n(we1), .oe_n(oe1), .addr(ad1), .dq(dq1));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Per-cycle pin check for one instance; k counts negedges after acceptance.
    task automatic check_inst(input int inst, input bit wr, input int k,
                              input int S, input int P, input int H, input int A,
                              input logic [16:0] ea, input bit bank, input logic [7:0] ed,
                              input logic [1:0] s1n, input logic s2, input logic we_n,
                              input logic oe_n, input logic ready, input logic dn,
                              input logic [16:0] addr, input logic [7:0] dq,
                              input logic [7:0] rd);
        int         dur;
        logic [1:0] sel_on;
        logic       s2_off;
        logic       exp_we;
        dur    = wr ? (S + P + H) : A;
        sel_on = (inst == 1 && bank) ? 2'b01 : 2'b10;
        s2_off = (inst == 1);
        if (k <= dur) begin
            check(s1n == sel_on && s2 == 1'b1, $sformatf("R8 inst%0d active select", inst),
                  32'({s1n, s2}), 32'({sel_on, 1'b1}));
            check(addr == ea, $sformatf("R9 inst%0d address held k=%0d", inst, k), 32'(addr), 32'(ea));
            check(!ready && !dn, $sformatf("R2 inst%0d busy k=%0d", inst, k), 32'({ready, dn}), 32'(0));
            if (wr) begin
                exp_we = (k > S && k <= S + P) ? 1'b0 : 1'b1;
                check(we_n == exp_we, $sformatf("R3 inst%0d strobe k=%0d", inst, k), 32'(we_n), 32'(exp_we));
                check(oe_n == 1'b1, $sformatf("R5 inst%0d oe high in write k=%0d", inst, k), 32'(oe_n), 32'(1));
                if (k > S)
                    check(dq == ed, $sformatf("R4 inst%0d write data k=%0d", inst, k), 32'(dq), 32'(ed));
            end else begin
                check(we_n == 1'b1 && oe_n == 1'b0, $sformatf("R6 inst%0d read controls k=%0d", inst, k),
                      32'({we_n, oe_n}), 32'(2'b10));
                check(dq == ed, $sformatf("R6 inst%0d device data k=%0d", inst, k), 32'(dq), 32'(ed));
            end
        end else if (k == dur + 1) begin
            check(dn && !ready, $sformatf("R7 inst%0d done pulse", inst), 32'({dn, ready}), 32'(2'b10));
            check(s1n == 2'b11 && s2 == s2_off && we_n && oe_n, $sformatf("R7 inst%0d released at done", inst),
                  32'({s1n, s2, we_n, oe_n}), 32'({2'b11, s2_off, 2'b11}));
            if (!wr)
                check(rd == ed, $sformatf("R6 inst%0d read data", inst), 32'(rd), 32'(ed));
        end else begin
            check(ready && !dn, $sformatf("R2 inst%0d ready again k=%0d", inst, k), 32'({ready, dn}), 32'(2'b10));
            check(s1n == 2'b11 && s2 == s2_off, $sformatf("R8 inst%0d idle select", inst),
                  32'({s1n, s2}), 32'({2'b11, s2_off}));
            if (!wr)
                check(rd == ed, $sformatf("R7 inst%0d read data held", inst), 32'(rd), 32'(ed));
        end
    endtask

    task automatic access(input bit wr, input logic [17:0] a, input logic [7:0] d,
                          input logic [7:0] e0, input logic [7:0] e1, input bit poke);
        int d0, d1, kmax;
        d0   = wr ? (S0 + P0 + H0) : A0;
        d1   = wr ? (S1 + P1 + H1) : A1;
        kmax = ((d0 > d1) ? d0 : d1) + 2;
        @(negedge clk);
        check(rdy0 && rdy1, "R2 ready before request", 32'({rdy0, rdy1}), 32'(2'b11));
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        for (int k = 1; k <= kmax; k++) begin
            @(negedge clk);
            check_inst(0, wr, k, S0, P0, H0, A0, a[16:0], a[17], wr ? d : e0,
                       s1n0, s20, we0, oe0, rdy0, dn0, ad0, dq0, rd0);
            check_inst(1, wr, k, S1, P1, H1, A1, a[16:0], a[17], wr ? d : e1,
                       s1n1, s21, we1, oe1, rdy1, dn1, ad1, dq1, rd1);
            if (k == 1) begin
                if (poke) begin
                    req_write = 1'b1;
                    req_wdata = ~d;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (k == 2) req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [17:0] ad;
        logic [7:0]  dv;
        logic        bk;

        // R1: reset state
        repeat (2) @(negedge clk);
        check(rdy0 && !dn0 && we0 && oe0 && s1n0 == 2'b11 && !s20, "R1 inst0 in reset",
              32'({rdy0, dn0, we0, oe0, s1n0, s20}), 32'(7'b1011110));
        check(rdy1 && !dn1 && we1 && oe1 && s1n1 == 2'b11 && s21, "R1 inst1 in reset",
              32'({rdy1, dn1, we1, oe1, s1n1, s21}), 32'(7'b1011111));
        rst = 1'b0;
        @(negedge clk);
        check(rdy0 && !dn0 && we0 && oe0 && s1n0 == 2'b11 && !s20, "R1 inst0 after reset",
              32'({rdy0, dn0, we0, oe0, s1n0, s20}), 32'(7'b1011110));
        check(rdy1 && !dn1 && we1 && oe1 && s1n1 == 2'b11 && s21, "R1 inst1 after reset",
              32'({rdy1, dn1, we1, oe1, s1n1, s21}), 32'(7'b1011111));

        // Pass 1: bank = a[0]; R10 minimum timing on inst1; R2 busy pokes
        for (int a = 0; a < 256; a++) begin
            bk = a[0];
            dv = 8'(a * 29 + 7);
            ad = {bk, 9'(a * 3), 8'(a)};
            access(1'b1, ad, dv, 8'h00, 8'h00, (a % 5) == 0);
            ref0[a]     = dv;
            ref1[bk][a] = dv;
        end
        // Pass 2: the other bank, different data
        for (int a = 0; a < 256; a++) begin
            bk = ~a[0];
            dv = 8'(a ^ 8'h5A) + 8'd3;
            ad = {bk, 9'(a * 7 + 1), 8'(a)};
            access(1'b1, ad, dv, 8'h00, 8'h00, (a % 7) == 3);
            ref0[a]     = dv;
            ref1[bk][a] = dv;
        end
        // Read both banks of every low address
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 2; b++) begin
                ad = {1'(b), 9'(a + b * 100), 8'(a)};
                access(1'b0, ad, 8'h00, ref0[a], ref1[b][a], (a % 9) == 0);
            end
        end
        finish_run();
    end
endmodule